// File: doc/BRIEF.md
# Array Descriptor Index and Reference Checker

The block takes a word that describes an array in memory, together with a signed element index and an operation code, and answers within one clock cycle. For an index operation it checks the index against the array's length and, when the index is legal, returns a rewritten descriptor that points at a single element. For a read or a write it checks that the array is resident in main memory and writable, and it forms the absolute element address from the descriptor's base and length fields. Any violation is reported as a two-bit interrupt cause instead of a result.

A processor's operand path drives it with a one-cycle start strobe. A done pulse follows on the next cycle, together with the registered descriptor, address and cause. The results hold until the next start. Moving data in from backing store and running the interrupt handler are left to other parts of the system.

Top module: `dix_top`

## Requirements
- R1: `done` is high exactly in the cycle after a cycle with `start` high. `desc_out`, `addr_out` and `cause` load only on a start and hold otherwise. Reset clears all outputs to zero.
- R2: The descriptor is laid out as follows. Bits [19:0] hold the base address and bits [39:20] hold the length. Bit 40 is copy, bit 41 is read-only, bit 42 is double, bit 43 is indexed and bit 44 is present.
- R3: Operation codes are 0 for index, 1 for read and 2 for write, and code 3 acts as a read. Cause codes are 0 for none, 1 for absent, 2 for read-only violation and 3 for invalid index.
- R4: When the double bit is 1, the index is doubled before the range check and before it is stored.
- R5: An index operation with a negative index, or with a (scaled) index greater than or equal to the length, gives cause 3. The descriptor is returned unchanged.
- R6: An index operation on a descriptor whose indexed bit is already 1 gives cause 3.
- R7: A legal index operation gives cause 0. The length is replaced by the scaled index and the indexed bit is set. All other fields, the copy bit included, are unchanged. `addr_out` is 0. Indexing does not check the present or read-only bits.
- R8: A read or write through a descriptor with present equal to 0 gives cause 1 and `addr_out` equal to 0.
- R9: A write through a present descriptor whose read-only bit is 1 gives cause 2. A read through the same descriptor is allowed.
- R10: A read or write through a present descriptor that is not indexed gives cause 3.
- R11: A read or write that passes its checks gives cause 0 and `addr_out` = (base + length) mod 2^20. `desc_out` equals `desc_in`.
- R12: Causes are ranked absent over read-only over invalid index. On any fault, `desc_out` equals `desc_in` and `addr_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, one cycle per request |
| op | input | 2 | Operation code |
| desc_in | input | 45 | Descriptor to use |
| index_in | input | 24 | Signed element index |
| desc_out | output | 45 | Updated or returned descriptor |
| addr_out | output | 20 | Absolute element address |
| done | output | 1 | Result valid pulse |
| cause | output | 2 | Interrupt cause, 0 when clean |

## Verification
Index requests are tried with single and double descriptors at the last legal element and at the first illegal one. A scaling fault is visible only at the boundary, so these cases separate a missing doubling from an off-by-one compare. Negative, zero-length and already-indexed cases separate the three routes into the invalid-index cause. Read and write requests combine the present, read-only and indexed bits so that every pair of causes meets, which exposes any swap in priority. A base near the top of the address space checks that the address wraps. Back-to-back requests check that each result belongs to its own start.

// File: rtl/dix_pkg.sv
package dix_pkg;
  localparam int unsigned DEF_ADDR_W = 20;
  localparam int unsigned DEF_LEN_W  = 20;
  localparam int unsigned DEF_IDX_W  = 24;
  localparam int unsigned FLAG_CNT   = 5;

  typedef enum logic [1:0] {
    OP_INDEX = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CZ_NONE   = 2'd0,
    CZ_ABSENT = 2'd1,
    CZ_RDONLY = 2'd2,
    CZ_BADIDX = 2'd3
  } cause_e;
endpackage

// File: rtl/dix_scale_check.sv
module dix_scale_check #(
  parameter int unsigned LEN_W = 20,
  parameter int unsigned IDX_W = 24
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             dbl,
  input  logic             already,
  input  logic [LEN_W-1:0] len,
  output logic             bad,
  output logic [LEN_W-1:0] new_len
);
  localparam int unsigned SC_W  = IDX_W + 1;
  localparam int unsigned CMP_W = (SC_W > LEN_W) ? SC_W : LEN_W;

  logic [SC_W-1:0]  scaled;
  logic [CMP_W-1:0] scaled_x;
  logic [CMP_W-1:0] len_x;
  logic             neg;

  always_comb begin
    neg      = idx[IDX_W-1];
    scaled   = dbl ? {idx, 1'b0} : {idx[IDX_W-1], idx};
    scaled_x = CMP_W'(scaled);
    len_x    = CMP_W'(len);
    bad      = already | neg | (scaled_x >= len_x);
    new_len  = LEN_W'(scaled_x);
  end
endmodule

// File: rtl/dix_fault_pri.sv
module dix_fault_pri
  import dix_pkg::*;
(
  input  logic   is_index,
  input  logic   is_write,
  input  logic   present,
  input  logic   rdonly,
  input  logic   indexed,
  input  logic   range_bad,
  output cause_e cause
);
  always_comb begin
    if (is_index) begin
      cause = range_bad ? CZ_BADIDX : CZ_NONE;
    end else if (!present) begin
      cause = CZ_ABSENT;
    end else if (is_write && rdonly) begin
      cause = CZ_RDONLY;
    end else if (!indexed) begin
      cause = CZ_BADIDX;
    end else begin
      cause = CZ_NONE;
    end
  end
endmodule

// File: rtl/dix_addr_gen.sv
module dix_addr_gen #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LEN_W  = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  offs,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned SUM_W = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = SUM_W'(base) + SUM_W'(offs);
    addr = ADDR_W'(sum);
  end
endmodule

// File: rtl/dix_top.sv
module dix_top
  import dix_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LEN_W  = DEF_LEN_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  localparam int unsigned DESC_W = ADDR_W + LEN_W + FLAG_CNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DESC_W-1:0] desc_in,
  input  logic [IDX_W-1:0]  index_in,
  output logic [DESC_W-1:0] desc_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              done,
  output logic [1:0]        cause
);
  localparam int unsigned LEN_LSB = ADDR_W;
  localparam int unsigned FLG_LSB = ADDR_W + LEN_W;
  localparam int unsigned B_RDO   = FLG_LSB + 1;
  localparam int unsigned B_DBL   = FLG_LSB + 2;
  localparam int unsigned B_IDXD  = FLG_LSB + 3;
  localparam int unsigned B_PRES  = FLG_LSB + 4;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [ADDR_W-1:0] base_f;
  logic [LEN_W-1:0]  len_f;
  logic              f_pres, f_idxd, f_dbl, f_rdo;
  logic              is_index, is_write;

  always_comb begin
    base_f   = desc_in[ADDR_W-1:0];
    len_f    = desc_in[LEN_LSB +: LEN_W];
    f_rdo    = desc_in[B_RDO];
    f_dbl    = desc_in[B_DBL];
    f_idxd   = desc_in[B_IDXD];
    f_pres   = desc_in[B_PRES];
    is_index = (op_e'(op) == OP_INDEX);
    is_write = (op_e'(op) == OP_WRITE);
  end

  logic             range_bad;
  logic [LEN_W-1:0] new_len;

  dix_scale_check #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_scale (
    .idx     (index_in),
    .dbl     (f_dbl),
    .already (f_idxd),
    .len     (len_f),
    .bad     (range_bad),
    .new_len (new_len)
  );

  cause_e cause_c;

  dix_fault_pri u_pri (
    .is_index  (is_index),
    .is_write  (is_write),
    .present   (f_pres),
    .rdonly    (f_rdo),
    .indexed   (f_idxd),
    .range_bad (range_bad),
    .cause     (cause_c)
  );

  logic [ADDR_W-1:0] addr_c;

  dix_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .base (base_f),
    .offs (len_f),
    .addr (addr_c)
  );

  logic [DESC_W-1:0] desc_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [1:0]        cause_nx;
  logic              done_nx;
  logic              load_en;

  always_comb begin
    load_en  = start;
    done_nx  = start;
    cause_nx = cause_c;
    desc_nx  = desc_in;
    addr_nx  = '0;
    if (cause_c == CZ_NONE) begin
      if (is_index) begin
        desc_nx[LEN_LSB +: LEN_W] = new_len;
        desc_nx[B_IDXD]           = 1'b1;
      end else begin
        addr_nx = addr_c;
      end
    end
  end

  logic [DESC_W-1:0] desc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        cause_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      desc_q  <= '0;
      addr_q  <= '0;
      cause_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_nx;
      if (load_en) begin
        desc_q  <= desc_nx;
        addr_q  <= addr_nx;
        cause_q <= cause_nx;
      end
    end
  end

  assign desc_out = desc_q;
  assign addr_out = addr_q;
  assign cause    = cause_q;
  assign done     = done_q;
endmodule

// File: rtl/dix_checker.sv
module dix_checker #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LEN_W  = 20,
  parameter int unsigned IDX_W  = 24,
  localparam int unsigned DESC_W = ADDR_W + LEN_W + 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op,
  input logic [DESC_W-1:0] desc_in,
  input logic [IDX_W-1:0]  index_in,
  input logic [DESC_W-1:0] desc_out,
  input logic [ADDR_W-1:0] addr_out,
  input logic              done,
  input logic [1:0]        cause
);
  localparam int unsigned FL = ADDR_W + LEN_W;

  // R1: a result follows every start, and only a start
  a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(desc_out) && $stable(addr_out) && $stable(cause)));

  // R7: the copy bit always passes through
  a_r7_copy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> desc_out[FL] == $past(desc_in[FL]));

  // R7: a clean index sets the indexed flag
  a_r7_index_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd0) |=> (cause != 2'd0 || desc_out[FL+3]));

  // R8: an absent descriptor blocks any access
  a_r8_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op != 2'd0 && !desc_in[FL+4]) |=> cause == 2'd1);

  // R9: a write to a protected resident area
  a_r9_rdonly: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd2 && desc_in[FL+4] && desc_in[FL+1]) |=> cause == 2'd2);

  // R6: re-indexing is refused
  a_r6_reindex: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd0 && desc_in[FL+3]) |=> cause == 2'd3);

  // R12: a fault yields no address and the descriptor as given
  a_r12_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cause != 2'd0) |-> (addr_out == '0 && desc_out == $past(desc_in)));

  logic unused_ok;
  assign unused_ok = ^index_in;
endmodule

bind dix_top dix_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .op       (op),
  .desc_in  (desc_in),
  .index_in (index_in),
  .desc_out (desc_out),
  .addr_out (addr_out),
  .done     (done),
  .cause    (cause)
);

// File: tb/dix_top_tb_top.sv
module dix_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int LW = 20;
  localparam int IW = 24;
  localparam int DW = AW + LW + 5;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [1:0]    op;
  logic [DW-1:0] desc_in;
  logic [IW-1:0] index_in;
  logic [DW-1:0] desc_out;
  logic [AW-1:0] addr_out;
  logic          done;
  logic [1:0]    cause;

  dix_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .desc_in(desc_in), .index_in(index_in),
    .desc_out(desc_out), .addr_out(addr_out), .done(done), .cause(cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    logic [1:0]    c;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks   = 0;
  int   failures = 0;
  bit   finished = 0;

  function automatic logic [DW-1:0] mk(bit p, bit ix, bit db, bit ro, bit cp,
                                       int unsigned len, int unsigned base);
    logic [DW-1:0] v;
    v = '0;
    v[AW-1:0]     = base[AW-1:0];
    v[AW +: LW]   = len[LW-1:0];
    v[AW+LW]      = cp;
    v[AW+LW+1]    = ro;
    v[AW+LW+2]    = db;
    v[AW+LW+3]    = ix;
    v[AW+LW+4]    = p;
    return v;
  endfunction

  function automatic exp_t model(logic [DW-1:0] d, int idx, logic [1:0] o, string tag);
    exp_t e;
    longint sc;
    longint len;
    e.d = d; e.a = '0; e.c = 2'd0; e.tag = tag;
    len = longint'(d[AW +: LW]);
    if (o == 2'd0) begin
      sc = d[AW+LW+2] ? longint'(idx) * 2 : longint'(idx);
      if (d[AW+LW+3] || idx < 0 || sc >= len) e.c = 2'd3;
      else begin
        e.d[AW +: LW]  = sc[LW-1:0];
        e.d[AW+LW+3]   = 1'b1;
      end
    end else begin
      if (!d[AW+LW+4])                   e.c = 2'd1;
      else if (o == 2'd2 && d[AW+LW+1])  e.c = 2'd2;
      else if (!d[AW+LW+3])              e.c = 2'd3;
      else e.a = AW'(longint'(d[AW-1:0]) + len);
    end
    return e;
  endfunction

  task automatic drive(logic [DW-1:0] d, int idx, logic [1:0] o, string tag);
    @(negedge clk);
    exp_q.push_back(model(d, idx, o, tag));
    desc_in  = d;
    index_in = idx[IW-1:0];
    op       = o;
    start    = 1'b1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start    = 1'b0;
      desc_in  = '1;
      index_in = '1;
      op       = 2'd2;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected done: actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (desc_out !== e.d || addr_out !== e.a || cause !== e.c) begin
          failures++;
          $display("FAIL %s: actual desc=%h addr=%h cause=%0d expected desc=%h addr=%h cause=%0d",
                   e.tag, desc_out, addr_out, cause, e.d, e.a, e.c);
        end
      end
    end
  end

  task automatic expect_hold(logic [DW-1:0] d, logic [AW-1:0] a, logic [1:0] c, string tag);
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || desc_out !== d || addr_out !== a || cause !== c) begin
      failures++;
      $display("FAIL %s: actual done=%b desc=%h addr=%h cause=%0d expected done=0 desc=%h addr=%h cause=%0d",
               tag, done, desc_out, addr_out, cause, d, a, c);
    end
  endtask

  initial begin
    start = 1'b0; op = 2'd0; desc_in = '0; index_in = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_hold('0, '0, 2'd0, "R1 reset state");
    repeat (4) @(negedge clk);

    // index operations
    drive(mk(1,0,0,0,0,10,20'h100), 3,  2'd0, "R7 single index");
    drive(mk(1,0,0,0,0,10,20'h100), 9,  2'd0, "R5 last legal element");
    drive(mk(1,0,0,0,0,10,20'h100), 10, 2'd0, "R5 index equals length");
    drive(mk(1,0,1,0,0,10,20'h100), 3,  2'd0, "R4 double scaled");
    drive(mk(1,0,1,0,0,10,20'h100), 5,  2'd0, "R4 double at length");
    drive(mk(1,0,1,0,0,11,20'h100), 5,  2'd0, "R4 double last legal");
    drive(mk(1,0,0,0,0,10,20'h100), -1, 2'd0, "R5 negative index");
    drive(mk(1,0,0,0,0,0, 20'h100), 0,  2'd0, "R5 zero length");
    drive(mk(1,1,0,0,0,10,20'h100), 2,  2'd0, "R6 already indexed");
    drive(mk(0,0,0,1,1,8, 20'h2A0), 4,  2'd0, "R7 absent readonly copy index");
    idle(1);
    // accesses
    drive(mk(0,1,0,0,0,4,20'h200),  0, 2'd1, "R8 read absent");
    drive(mk(0,1,0,1,0,4,20'h200),  0, 2'd2, "R12 absent over readonly");
    drive(mk(1,1,0,1,0,4,20'h200),  0, 2'd2, "R9 write readonly");
    drive(mk(1,0,0,1,0,4,20'h200),  0, 2'd2, "R12 readonly over unindexed");
    drive(mk(1,1,0,1,0,4,20'h200),  0, 2'd1, "R9 read readonly allowed");
    drive(mk(1,0,0,0,0,4,20'h200),  0, 2'd1, "R10 read unindexed");
    drive(mk(1,1,0,0,1,7,20'h3F0),  0, 2'd2, "R11 write address");
    drive(mk(1,1,0,0,0,2,20'hFFFFF),0, 2'd3, "R3 code 3 reads, R11 wrap");
    drive(mk(1,1,1,0,0,6,20'h010),  0, 2'd1, "R2 field layout read");
    idle(1);
    expect_hold(mk(1,1,1,0,0,6,20'h010), 20'h016, 2'd0, "R1 outputs hold");
    expect_hold(mk(1,1,1,0,0,6,20'h010), 20'h016, 2'd0, "R1 outputs hold again");
    idle(3);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results: actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule